// File: doc/BRIEF.md
# DSP Address Generator

This block produces data-memory addresses for signal-processing loops from a single pointer. Software, or a sequencer, loads a base address, a buffer length K, a step and an addressing mode in one cycle. After that, each request cycle moves the pointer on according to the mode. The address output is combinational from the pointer state, so it always shows the address to use for the next access.

The block has three modes:

- **Linear.** Adds the step without bound.
- **Circular.** Keeps an offset inside a window of K words starting at the base. This lets a filter delay line overwrite its oldest sample in place instead of shifting every stored sample.
- **Bit-reversed.** Counts through 0..K-1 and emits each count with its low log2(K) bits mirrored. This is the reordered index sequence an FFT needs.

Top module: `dsp_agu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state clears: the address becomes 0 and the mode becomes linear.
- R2: In linear mode (`cfg_mode` = 0), each request adds the 32-bit step to the address, with wraparound modulo 2^32 and no other bound.
- R3: In circular mode (`cfg_mode` = 1), the address is base + offset. Each request replaces the offset with (offset + step) mod K. For steps below K, the address therefore stays inside [base, base+K-1].
- R4: In circular mode, a loaded length of 0 is treated as 1, and a length of 1 holds the address at base on every request.
- R5: In bit-reversed mode (`cfg_mode` = 2, K a power of two), a counter starts at 0 and steps by one per request, wrapping from K-1 to 0. The step is ignored. The address is base plus the counter with bits 0..log2(K)-1 reversed in order.
- R6: A clock edge with `cfg_load` high captures base, length, step and mode, and sets the pointer to base. The next address shown is base. A request in the same cycle is ignored.
- R7: A cycle with neither `cfg_load` nor `req` leaves the address unchanged.
- R8: Mode code 3 behaves exactly like linear mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load configuration and reset the pointer to base |
| cfg_mode | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| cfg_base | input | 32 | Buffer base address |
| cfg_len | input | LEN_W (8) | Buffer length K |
| cfg_step | input | 32 | Pointer increment (must be below K in circular mode) |
| req | input | 1 | Advance the pointer at this edge |
| addr | output | 32 | Current address |

## Verification
The circular sweep covers every step below K for every small K, running past several wraps. A design that subtracted K at the wrong threshold would leave the window or skip slot 0. K = 0 and K = 1 are included, so a design without the zero-length guard would produce out-of-window offsets. The bit-reversed sweep covers every power-of-two length up to 128. A reversal over the wrong number of bits would emit scaled or out-of-range offsets, and a counter that wrapped late would repeat the first index. The linear runs start just below 2^32, which catches a carry that was truncated or saturated. A load that coincides with a request would show a step from base, rather than base itself, if load priority were wrong.

// File: rtl/agu_pkg.sv
// Package: shared mode encoding for the address generator.
// Assumes a 2-bit mode field; code 3 is decoded as linear by the datapath.
package agu_pkg;
    typedef enum logic [1:0] {
        MODE_LINEAR = 2'd0,
        MODE_CIRC   = 2'd1,
        MODE_BITREV = 2'd2,
        MODE_RSVD   = 2'd3
    } agu_mode_e;
endpackage

// File: rtl/agu_len_log2.sv
// Module: floor(log2) of a buffer length, i.e. the index of its highest set bit.
// Assumes len_i is at least 1; for a power of two the result is exact.
module agu_len_log2 #(
    parameter int LEN_W = 8,
    localparam int NB_W = $clog2(LEN_W + 1)
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [NB_W-1:0]  nbits_o
);
    // Priority scan: the last set bit seen wins.
    always_comb begin
        nbits_o = '0;
        for (int i = 0; i < LEN_W; i++) begin
            if (len_i[i]) nbits_o = NB_W'(i);
        end
    end
endmodule

// File: rtl/agu_wrap_add.sv
// Module: modular adder, (val + inc) mod lim, done as one conditional subtract.
// Assumes val_i < lim_i and inc_i < lim_i, so a single subtraction suffices.
module agu_wrap_add #(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] val_i,
    input  logic [LEN_W-1:0] inc_i,
    input  logic [LEN_W-1:0] lim_i,
    output logic [LEN_W-1:0] sum_o
);
    logic [LEN_W:0] raw;

    // Wide sum, then remove one lim when it reaches or passes it.
    always_comb begin
        raw = {1'b0, val_i} + {1'b0, inc_i};
        if (raw >= {1'b0, lim_i}) raw = raw - {1'b0, lim_i};
        sum_o = raw[LEN_W-1:0];
    end
endmodule

// File: rtl/agu_bit_rev.sv
// Module: mirrors the low nbits_i bits of a counter value.
// Assumes val_i < 2**nbits_i; reverses all LEN_W bits, then shifts right
// by (LEN_W - nbits_i) so that only the meaningful bits remain.
module agu_bit_rev #(
    parameter int LEN_W = 8,
    localparam int NB_W = $clog2(LEN_W + 1)
) (
    input  logic [LEN_W-1:0] val_i,
    input  logic [NB_W-1:0]  nbits_i,
    output logic [LEN_W-1:0] rev_o
);
    logic [LEN_W-1:0] full_rev;
    logic [NB_W-1:0]  shamt;

    for (genvar g = 0; g < LEN_W; g++) begin : g_mirror
        assign full_rev[g] = val_i[LEN_W-1-g];
    end

    // Align the mirrored field to bit 0.
    always_comb begin
        shamt = NB_W'(LEN_W) - nbits_i;
        rev_o = full_rev >> shamt;
    end
endmodule

// File: rtl/dsp_agu.sv
// Module: single-pointer address generator with linear, circular and
// bit-reversed modes. The address is combinational from the registered
// base and offset. Assumes step < K in circular mode and K a power of two
// in bit-reversed mode.
module dsp_agu #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    localparam int NB_W  = $clog2(LEN_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [ADDR_W-1:0] cfg_step,
    input  logic              req,
    output logic [ADDR_W-1:0] addr
);
    import agu_pkg::*;

    agu_mode_e         mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] step_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] off_q;
    logic [ADDR_W-1:0] off_nxt;
    logic [LEN_W-1:0]  circ_nxt;
    logic [LEN_W-1:0]  cnt_nxt;
    logic [LEN_W-1:0]  rev_off;
    logic [NB_W-1:0]   nbits;

    agu_wrap_add #(.LEN_W(LEN_W)) u_circ_add (
        .val_i(off_q[LEN_W-1:0]), .inc_i(step_q[LEN_W-1:0]),
        .lim_i(len_q), .sum_o(circ_nxt)
    );

    agu_wrap_add #(.LEN_W(LEN_W)) u_cnt_add (
        .val_i(off_q[LEN_W-1:0]), .inc_i(LEN_W'(1)),
        .lim_i(len_q), .sum_o(cnt_nxt)
    );

    agu_len_log2 #(.LEN_W(LEN_W)) u_log2 (.len_i(len_q), .nbits_o(nbits));

    agu_bit_rev #(.LEN_W(LEN_W)) u_rev (
        .val_i(off_q[LEN_W-1:0]), .nbits_i(nbits), .rev_o(rev_off)
    );

    // Select the offset update for the active mode.
    always_comb begin
        case (mode_q)
            MODE_CIRC:   off_nxt = ADDR_W'(circ_nxt);
            MODE_BITREV: off_nxt = ADDR_W'(cnt_nxt);
            default:     off_nxt = off_q + step_q;
        endcase
    end

    // Form the output address from base and the mode's view of the offset.
    always_comb begin
        case (mode_q)
            MODE_CIRC:   addr = base_q + ADDR_W'(off_q[LEN_W-1:0]);
            MODE_BITREV: addr = base_q + ADDR_W'(rev_off);
            default:     addr = base_q + off_q;
        endcase
    end

    // Configuration capture (load has priority) and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_LINEAR;
            base_q <= '0;
            step_q <= '0;
            len_q  <= LEN_W'(1);
            off_q  <= '0;
        end else if (cfg_load) begin
            mode_q <= agu_mode_e'(cfg_mode);
            base_q <= cfg_base;
            step_q <= cfg_step;
            len_q  <= (cfg_len == '0) ? LEN_W'(1) : cfg_len;
            off_q  <= '0;
        end else if (req) begin
            off_q  <= off_nxt;
        end
    end

    // Windowed modes keep the offset below K.
    assert_off_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CIRC || mode_q == MODE_BITREV) |-> (off_q < ADDR_W'(len_q)));

    // A load makes the next address equal to the loaded base.
    assert_load_gives_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (addr == $past(cfg_base)));

    // With no load and no request, the address holds.
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !req) |=> $stable(addr));

    // A linear request advances the address by exactly the step.
    assert_linear_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !cfg_load && (mode_q == MODE_LINEAR || mode_q == MODE_RSVD))
        |=> (addr == $past(addr) + $past(step_q)));

    // The mirrored offset keeps the counter's population count.
    assert_rev_popcount_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BITREV) |-> ($countones(rev_off) == $countones(off_q[LEN_W-1:0])));
endmodule

// File: tb/dsp_agu_test.sv
// Bench: sweeps every mode over small lengths and compares each address
// against an arithmetic model computed here.
module dsp_agu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [31:0] cfg_base = '0;
    logic [7:0]  cfg_len = '0;
    logic [31:0] cfg_step = '0;
    logic        req = 1'b0;
    logic [31:0] addr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsp_agu uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_step(cfg_step),
        .req(req), .addr(addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: addr=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply inputs, then sample 2 ns after the rising edge.
    task automatic tick(input logic l, input logic r);
        cfg_load = l;
        req = r;
        @(posedge clk);
        #2;
        cfg_load = 1'b0;
        req = 1'b0;
    endtask

    task automatic load(input logic [1:0] m, input logic [31:0] b,
                        input logic [7:0] k, input logic [31:0] s, input logic r);
        cfg_mode = m; cfg_base = b; cfg_len = k; cfg_step = s;
        tick(1'b1, r);
    endtask

    function automatic int mirror(input int v, input int n);
        int r = 0;
        for (int i = 0; i < n; i++) r |= ((v >> i) & 1) << (n - 1 - i);
        return r;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        @(posedge clk); #2;
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        check("R1 reset address", addr, 32'h0);
        rst_n = 1'b1;
        tick(1'b0, 1'b1);
        check("R1 reset mode linear, step 0", addr, 32'h0);

        // R2: linear across the 2^32 boundary
        load(2'd0, 32'hFFFF_FFF0, 8'd4, 32'd3, 1'b0);
        check("R6 load returns base", addr, 32'hFFFF_FFF0);
        exp = 32'hFFFF_FFF0;
        for (int i = 0; i < 12; i++) begin
            tick(1'b0, 1'b1);
            exp = exp + 32'd3;
            check("R2 linear step", addr, exp);
        end
        tick(1'b0, 1'b0);
        check("R7 idle hold", addr, exp);

        // R8: reserved code acts as linear
        load(2'd3, 32'h0000_1000, 8'd2, 32'h0001_0000, 1'b0);
        exp = 32'h0000_1000;
        for (int i = 0; i < 6; i++) begin
            tick(1'b0, 1'b1);
            exp = exp + 32'h0001_0000;
            check("R8 code 3 linear", addr, exp);
        end

        // R3/R4: circular sweep over K = 0..12, every step below K
        for (int k = 0; k < 13; k++) begin
            int keff = (k == 0) ? 1 : k;
            for (int s = 0; s < keff; s++) begin
                int off = 0;
                load(2'd1, 32'h0000_8000 + 32'(k * 64), 8'(k), 32'(s), 1'b0);
                check("R6 circular load base", addr, 32'h0000_8000 + 32'(k * 64));
                for (int i = 0; i < 2 * keff + 3; i++) begin
                    tick(1'b0, 1'b1);
                    off = (off + s) % keff;
                    if (k < 2)
                        check("R4 short length holds base", addr, 32'h0000_8000 + 32'(k * 64));
                    else
                        check("R3 circular offset", addr, 32'h0000_8000 + 32'(k * 64) + 32'(off));
                end
                tick(1'b0, 1'b0);
                check("R7 idle hold circular", addr, 32'h0000_8000 + 32'(k * 64) + 32'(off));
            end
        end

        // R5: bit-reversed sweep over K = 1,2,4,...,128 (step ignored)
        for (int n = 0; n < 8; n++) begin
            int k = 1 << n;
            int cnt = 0;
            load(2'd2, 32'h4000_0000, 8'(k), 32'd5, 1'b0);
            check("R5 bitrev starts at base", addr, 32'h4000_0000);
            for (int i = 0; i < k + 2; i++) begin
                tick(1'b0, 1'b1);
                cnt = (cnt + 1) % k;
                check("R5 bitrev order", addr, 32'h4000_0000 + 32'(mirror(cnt, n)));
            end
        end

        // R6: a load mid-run, with a simultaneous request
        load(2'd1, 32'h0000_0200, 8'd8, 32'd3, 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        check("R3 before reload", addr, 32'h0000_0206);
        load(2'd0, 32'h0000_0300, 8'd8, 32'd7, 1'b1);
        check("R6 load wins over request", addr, 32'h0000_0300);
        tick(1'b0, 1'b1);
        check("R6 first request after load", addr, 32'h0000_0307);

        // R1: reset during operation
        rst_n = 1'b0;
        tick(1'b0, 1'b1);
        check("R1 reset clears address", addr, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule